// File: doc/BRIEF.md
# Monochrome Cursor Overlay

The block draws a 64x64 two-plane pointer over a stream of 32-bit display pixels. Pixels arrive one per beat on a valid/ready stream, with a start-of-line flag and the pixel's horizontal coordinate as sideband. The block keeps its own scanline count, which a frame-start pulse clears. Every beat leaves the block exactly two cycles after it is accepted, unless the output stalls. A beat inside the cursor rectangle is replaced, inverted or left alone, as the bitmap dictates.

The bitmap lives in an internal line memory that a byte-wide write port fills. Each cursor row holds a mask plane and a pattern plane. Per pixel, the two planes choose one of four results: transparent, invert, colour 0 or colour 1. A register port sets the position, the two 24-bit colours, an enable bit and a lock bit. Register writes go to staging copies first. The copies used for drawing take them over only at a frame-start pulse, and only while the lock is clear.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, out_valid is low, in_ready is high and the cursor is disabled, so beats pass through unchanged.
- R2: An accepted beat appears on the output two clock edges later. While out_valid is high and out_ready is low, out_valid and out_pix hold and in_ready is low.
- R3: Bitmap byte address = row*16 + byte. Bytes 0..7 of a row form the mask plane and bytes 8..15 form the pattern plane. Cursor column c uses byte c/8, bit 7-(c%8), so pixels are taken MSB first.
- R4: Mask 1 with pattern 1 outputs the bitwise complement of the incoming 32-bit pixel.
- R5: Mask 1 with pattern 0 leaves the incoming pixel unchanged.
- R6: Mask 0 outputs {colour,8'hFF}. The colour is colour 1 when the pattern bit is 1 and colour 0 when it is 0.
- R7: A line is touched only when enable is set, the line lies in [Y, Y+63] and the line is no greater than disp_vend.
- R8: Only columns in [X, X+63] that are also below disp_width are touched, so the cursor never spills onto the next line.
- R9: The register map is as follows. Address 0 holds X in bits 29:16 and Y in bits 11:0. Address 1 holds enable in bit 0. Address 2 holds colour 0 in bits 23:0 and address 3 holds colour 1 in bits 23:0. A write to address 0 or 1 sets the lock to bit 31 of the written data.
- R10: Register writes take effect only at the next frame_start pulse.
- R11: While the lock is set, a frame_start pulse applies nothing. After the lock is released, the next pulse applies every pending write.
- R12: frame_start resets the line count. The first start-of-line beat after it is line 0, and each later start-of-line beat advances the line by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| bm_we | input | 1 | Bitmap byte write strobe |
| bm_addr | input | 10 | Bitmap byte address |
| bm_wdata | input | 8 | Bitmap byte data |
| frame_start | input | 1 | One-cycle start-of-frame pulse |
| disp_width | input | 14 | Visible pixels per line |
| disp_vend | input | 12 | Last visible line |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_pix | input | 32 | Underlying pixel |
| in_sol | input | 1 | Beat starts a new line |
| in_x | input | 14 | Horizontal pixel coordinate |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts beat |
| out_pix | output | 32 | Pixel after overlay |

## Verification
The clip assertion assumes that disp_width does not change while beats are in the pipeline. The bench sets the geometry before any traffic and never changes it. The assertions also assume that frame_start is never raised together with a start-of-line beat. The bench pulses it only while no beat is being driven. Pipeline beats are sent one at a time, except for one deliberate output stall, so every expected pixel depends on a single known line and column.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
    localparam int COL_W     = 24;
    localparam int PIX_W     = COL_W + 8;
    localparam int X_W       = 14;
    localparam int Y_W       = 12;
    localparam int DATA_W    = 32;
    localparam int REG_AW    = 2;
    localparam int CUR_DIM   = 64;
    localparam int IDX_W     = $clog2(CUR_DIM);
    localparam int ROW_BYTES = CUR_DIM / 4;
    localparam int ROW_BITS  = ROW_BYTES * 8;
    localparam int RB_W      = $clog2(ROW_BITS);
    localparam int BYTE_SEL_W = $clog2(ROW_BYTES);
    localparam int BM_AW     = $clog2(CUR_DIM * ROW_BYTES);

    localparam int POS_X_LSB = 16;
    localparam int LOCK_BIT  = 31;
    localparam int EN_BIT    = 0;

    localparam logic [REG_AW-1:0] A_POS  = 2'd0;
    localparam logic [REG_AW-1:0] A_CTRL = 2'd1;
    localparam logic [REG_AW-1:0] A_COL0 = 2'd2;
    localparam logic [REG_AW-1:0] A_COL1 = 2'd3;

    typedef enum logic [1:0] {
        K_PASS = 2'd0,
        K_INV  = 2'd1,
        K_COL0 = 2'd2,
        K_COL1 = 2'd3
    } kind_e;

    typedef struct packed {
        logic             en;
        logic [X_W-1:0]   x;
        logic [Y_W-1:0]   y;
        logic [COL_W-1:0] c0;
        logic [COL_W-1:0] c1;
    } cfg_t;
endpackage

// File: rtl/cursor_shadow_regs.sv
module cursor_shadow_regs
    import cursor_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              frame_start,
    output cfg_t              act_cfg
);
    typedef struct packed {
        cfg_t host;
        cfg_t act;
        logic lock;
    } st_t;

    st_t st_d, st_q;

    logic unused_bits;
    assign unused_bits = ^{wr_data[30:POS_X_LSB+X_W], wr_data[POS_X_LSB-1:Y_W]};

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_addr)
                A_POS: begin
                    st_d.host.x = wr_data[POS_X_LSB +: X_W];
                    st_d.host.y = wr_data[Y_W-1:0];
                    st_d.lock   = wr_data[LOCK_BIT];
                end
                A_CTRL: begin
                    st_d.host.en = wr_data[EN_BIT];
                    st_d.lock    = wr_data[LOCK_BIT];
                end
                A_COL0:  st_d.host.c0 = wr_data[COL_W-1:0];
                default: st_d.host.c1 = wr_data[COL_W-1:0];
            endcase
        end
        if (frame_start && !st_q.lock) begin
            st_d.act = st_q.host;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_cfg = st_q.act;

    // R10: the drawing copy moves only on a frame pulse
    p_quiet_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(st_q.act));

    // R11: a locked frame pulse leaves the drawing copy alone
    p_lock_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && st_q.lock) |=> $stable(st_q.act));
endmodule

// File: rtl/cursor_bitmap_ram.sv
module cursor_bitmap_ram
    import cursor_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [BM_AW-1:0]    wr_addr,
    input  logic [7:0]          wr_data,
    input  logic [IDX_W-1:0]    rd_row,
    output logic [ROW_BITS-1:0] rd_bits
);
    logic [ROW_BITS-1:0] mem_d [CUR_DIM];
    logic [ROW_BITS-1:0] mem_q [CUR_DIM];

    logic [IDX_W-1:0]      w_row;
    logic [BYTE_SEL_W-1:0] w_byte;

    assign w_row  = wr_addr[BM_AW-1:BYTE_SEL_W];
    assign w_byte = wr_addr[BYTE_SEL_W-1:0];

    always_comb begin
        for (int r = 0; r < CUR_DIM; r++) mem_d[r] = mem_q[r];
        if (wr_en) mem_d[w_row][{w_byte, 3'b000} +: 8] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < CUR_DIM; r++) mem_q[r] <= '0;
        end else begin
            for (int r = 0; r < CUR_DIM; r++) mem_q[r] <= mem_d[r];
        end
    end

    assign rd_bits = mem_q[rd_row];
endmodule

// File: rtl/cursor_pixel_pipe.sv
module cursor_pixel_pipe
    import cursor_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [X_W-1:0]   disp_width,
    input  logic             s0_valid,
    output logic             s0_ready,
    input  logic [PIX_W-1:0] s0_pix,
    input  logic [X_W-1:0]   s0_x,
    input  kind_e            s0_kind,
    input  logic [COL_W-1:0] s0_colour,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PIX_W-1:0] out_pix
);
    typedef struct packed {
        logic             valid;
        logic [PIX_W-1:0] pix;
        logic [X_W-1:0]   x;
        kind_e            kind;
        logic [COL_W-1:0] colour;
    } s1_t;

    typedef struct packed {
        logic             valid;
        logic [PIX_W-1:0] pix;
    } s2_t;

    s1_t s1_d, s1_q;
    s2_t s2_d, s2_q;
    logic adv;

    assign adv = !s2_q.valid || out_ready;

    always_comb begin
        s1_d = s1_q;
        s2_d = s2_q;
        if (adv) begin
            s1_d.valid  = s0_valid;
            s1_d.pix    = s0_pix;
            s1_d.x      = s0_x;
            s1_d.kind   = s0_kind;
            s1_d.colour = s0_colour;
            s2_d.valid  = s1_q.valid;
            case (s1_q.kind)
                K_INV:   s2_d.pix = ~s1_q.pix;
                K_COL0,
                K_COL1:  s2_d.pix = {s1_q.colour, 8'hFF};
                default: s2_d.pix = s1_q.pix;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign s0_ready  = adv;
    assign out_valid = s2_q.valid;
    assign out_pix   = s2_q.pix;

    // R2: a stalled output beat holds still
    p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

    // R5: a pass-through beat leaves the pixel unchanged
    p_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && s1_q.valid && s1_q.kind == K_PASS) |=> (out_pix == $past(s1_q.pix)));

    // R4: an invert beat comes out complemented
    p_inv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && s1_q.valid && s1_q.kind == K_INV) |=> (out_pix == ~$past(s1_q.pix)));

    // R8: nothing at or past the display width is rewritten
    p_clip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_q.valid && s1_q.kind != K_PASS) |-> (s1_q.x < disp_width));
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
    import cursor_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              bm_we,
    input  logic [BM_AW-1:0]  bm_addr,
    input  logic [7:0]        bm_wdata,
    input  logic              frame_start,
    input  logic [X_W-1:0]    disp_width,
    input  logic [Y_W-1:0]    disp_vend,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PIX_W-1:0]  in_pix,
    input  logic              in_sol,
    input  logic [X_W-1:0]    in_x,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PIX_W-1:0]  out_pix
);
    localparam logic [Y_W-1:0] DIM_Y = Y_W'(CUR_DIM);
    localparam logic [X_W-1:0] DIM_X = X_W'(CUR_DIM);

    typedef struct packed {
        logic [Y_W-1:0] line;
        logic [Y_W-1:0] next_line;
    } lc_t;

    lc_t lc_d, lc_q;
    cfg_t cfg;

    logic [ROW_BITS-1:0] row_bits;
    logic [Y_W-1:0]      line_eff, dy;
    logic [X_W-1:0]      dx;
    logic [IDX_W-1:0]    col;
    logic                vhit, hhit, mask_b, patt_b;
    logic [RB_W-1:0]     mask_idx, patt_idx;
    kind_e               kind;
    logic [COL_W-1:0]    colour;
    logic                accept;

    cursor_shadow_regs i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_we),
        .wr_addr    (reg_addr),
        .wr_data    (reg_wdata),
        .frame_start(frame_start),
        .act_cfg    (cfg)
    );

    cursor_bitmap_ram i_ram (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bm_we),
        .wr_addr(bm_addr),
        .wr_data(bm_wdata),
        .rd_row (dy[IDX_W-1:0]),
        .rd_bits(row_bits)
    );

    assign accept = in_valid && in_ready;

    always_comb begin
        lc_d = lc_q;
        if (frame_start) begin
            lc_d.next_line = '0;
        end else if (accept && in_sol) begin
            lc_d.line      = lc_q.next_line;
            lc_d.next_line = lc_q.next_line + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lc_q <= '0;
        else        lc_q <= lc_d;
    end

    always_comb begin
        line_eff = in_sol ? lc_q.next_line : lc_q.line;
        dy       = line_eff - cfg.y;
        dx       = in_x - cfg.x;
        vhit     = cfg.en && (line_eff >= cfg.y) && (dy < DIM_Y) && (line_eff <= disp_vend);
        hhit     = (in_x >= cfg.x) && (dx < DIM_X) && (in_x < disp_width);
        col      = dx[IDX_W-1:0];
        mask_idx = {1'b0, col[IDX_W-1:3], ~col[2:0]};
        patt_idx = {1'b1, col[IDX_W-1:3], ~col[2:0]};
        mask_b   = row_bits[mask_idx];
        patt_b   = row_bits[patt_idx];
        colour   = patt_b ? cfg.c1 : cfg.c0;
        if (!(vhit && hhit))          kind = K_PASS;
        else if (mask_b && patt_b)    kind = K_INV;
        else if (mask_b)              kind = K_PASS;
        else if (patt_b)              kind = K_COL1;
        else                          kind = K_COL0;
    end

    cursor_pixel_pipe i_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .disp_width(disp_width),
        .s0_valid  (in_valid),
        .s0_ready  (in_ready),
        .s0_pix    (in_pix),
        .s0_x      (in_x),
        .s0_kind   (kind),
        .s0_colour (colour),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_pix   (out_pix)
    );

    // R12: a frame pulse restarts the line count at zero
    p_line_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (lc_q.next_line == '0));

    // R7: a disabled cursor never rewrites a beat
    p_disabled_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cfg.en) |-> (kind == K_PASS));
endmodule

// File: tb/test_cursor_overlay.sv
module test_cursor_overlay;
    import cursor_pkg::*;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WDOG_CYCLES = 150000;
    localparam int  NVEC = 12;
    localparam logic [13:0] WIDTH = 14'd40;
    localparam logic [11:0] VEND  = 12'd60;
    localparam logic [13:0] CX    = 14'd10;
    localparam logic [11:0] CY    = 12'd3;
    localparam logic [23:0] C0    = 24'h123456;
    localparam logic [23:0] C1    = 24'hABCDEF;

    // {line[57:46], x[45:32], pixel[31:0]}
    localparam logic [57:0] VEC [NVEC] = '{
        {12'd3,  14'd10, 32'h0F0F_1234},
        {12'd3,  14'd12, 32'h1111_2222},
        {12'd3,  14'd14, 32'h3333_4444},
        {12'd3,  14'd16, 32'h5555_6666},
        {12'd3,  14'd19, 32'h7777_8888},
        {12'd2,  14'd12, 32'h9999_AAAA},
        {12'd8,  14'd13, 32'hBBBB_CCCC},
        {12'd4,  14'd9,  32'hDDDD_EEEE},
        {12'd4,  14'd39, 32'h0102_0304},
        {12'd4,  14'd40, 32'h0506_0708},
        {12'd60, 14'd11, 32'h090A_0B0C},
        {12'd61, 14'd10, 32'h0D0E_0F10}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [1:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic              bm_we = 1'b0;
    logic [9:0]        bm_addr = '0;
    logic [7:0]        bm_wdata = '0;
    logic              frame_start = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [31:0]       in_pix = '0;
    logic              in_sol = 1'b0;
    logic [13:0]       in_x = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [31:0]       out_pix;

    int nchk = 0;
    int nbad = 0;
    bit done = 1'b0;

    logic [7:0]  bm [1024];
    logic        h_en, a_en, m_lock;
    logic [13:0] h_x, a_x;
    logic [11:0] h_y, a_y;
    logic [23:0] h_c0, a_c0, h_c1, a_c1;

    always #(CLK_PERIOD/2) clk = ~clk;

    cursor_overlay i_cursor_overlay (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .bm_we(bm_we), .bm_addr(bm_addr), .bm_wdata(bm_wdata),
        .frame_start(frame_start), .disp_width(WIDTH), .disp_vend(VEND),
        .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
        .in_sol(in_sol), .in_x(in_x),
        .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nbad++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] model(input logic [11:0] line, input logic [13:0] x,
                                          input logic [31:0] pix);
        int dx, dy;
        logic mb, pb;
        if (!a_en || line < a_y || int'(line) - int'(a_y) >= 64 || line > VEND ||
            x < a_x || int'(x) - int'(a_x) >= 64 || x >= WIDTH) return pix;
        dx = int'(x) - int'(a_x);
        dy = int'(line) - int'(a_y);
        mb = bm[dy*16 + dx/8][7 - dx%8];
        pb = bm[dy*16 + 8 + dx/8][7 - dx%8];
        if (mb && pb) return ~pix;
        if (mb) return pix;
        return {pb ? a_c1 : a_c0, 8'hFF};
    endfunction

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        case (a)
            2'd0: begin h_x = d[29:16]; h_y = d[11:0]; m_lock = d[31]; end
            2'd1: begin h_en = d[0]; m_lock = d[31]; end
            2'd2: h_c0 = d[23:0];
            default: h_c1 = d[23:0];
        endcase
    endtask

    task automatic wr_bm(input int a, input logic [7:0] d);
        @(negedge clk);
        bm_we = 1'b1; bm_addr = a[9:0]; bm_wdata = d;
        @(negedge clk);
        bm_we = 1'b0;
        bm[a] = d;
    endtask

    task automatic pulse_frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        if (!m_lock) begin
            a_en = h_en; a_x = h_x; a_y = h_y; a_c0 = h_c0; a_c1 = h_c1;
        end
    endtask

    task automatic send_beat(input logic sol, input logic [13:0] x, input logic [31:0] pix,
                             output logic [31:0] res);
        @(negedge clk);
        in_valid = 1'b1; in_sol = sol; in_x = x; in_pix = pix;
        @(negedge clk);
        in_valid = 1'b0; in_sol = 1'b0;
        @(negedge clk);
        res = out_pix;
    endtask

    task automatic goto_line(input int line);
        logic [31:0] dummy;
        pulse_frame();
        for (int i = 0; i <= line; i++) send_beat(1'b1, 14'd0, 32'h0, dummy);
    endtask

    task automatic line_check(input string tag, input logic [11:0] line,
                              input logic [13:0] x, input logic [31:0] pix);
        logic [31:0] res;
        goto_line(int'(line));
        send_beat(1'b0, x, pix, res);
        chk(tag, res, model(line, x, pix));
    endtask

    initial begin : watchdog
        repeat (WDOG_CYCLES) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] res, held;
        h_en = 0; a_en = 0; m_lock = 0;
        h_x = '0; a_x = '0; h_y = '0; a_y = '0;
        h_c0 = '0; a_c0 = '0; h_c1 = '0; a_c1 = '0;
        for (int i = 0; i < 1024; i++) bm[i] = 8'h00;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
        chk("R1 in_ready after reset", {31'd0, in_ready}, 32'd1);
        send_beat(1'b1, 14'd0, 32'hCAFE_F00D, res);
        chk("R1 disabled pass", res, 32'hCAFE_F00D);

        // R2: latency of two edges
        @(negedge clk);
        in_valid = 1'b1; in_sol = 1'b0; in_x = 14'd5; in_pix = 32'h0000_00A5;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 not valid after one edge", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        chk("R2 valid after two edges", {31'd0, out_valid}, 32'd1);
        chk("R2 data after two edges", out_pix, 32'h0000_00A5);

        // R3: bitmap load, mask F0 / pattern CC everywhere, with two exceptions
        for (int r = 0; r < 64; r++)
            for (int b = 0; b < 16; b++)
                wr_bm(r*16 + b, (b < 8) ? 8'hF0 : 8'hCC);
        wr_bm(1, 8'h00); wr_bm(9, 8'h00);
        for (int b = 0; b < 8; b++) begin
            wr_bm(5*16 + b, 8'h00);
            wr_bm(5*16 + 8 + b, 8'hFF);
        end

        // R9: register programming
        wr_reg(2'd0, {2'b00, CX, 4'h0, CY});
        wr_reg(2'd1, 32'h0000_0001);
        wr_reg(2'd2, {8'h00, C0});
        wr_reg(2'd3, {8'h00, C1});

        // table: R3 R4 R5 R6 R7 R8 R12
        for (int i = 0; i < NVEC; i++) begin
            line_check($sformatf("R3/R4/R5/R6/R7/R8/R12 vector %0d", i),
                       VEC[i][57:46], VEC[i][45:32], VEC[i][31:0]);
        end
        chk("R6 colour1 value at row 5", model(12'd8, 14'd13, 32'h0), 32'hABCDEF_FF);
        chk("R4 invert value", model(12'd3, 14'd10, 32'h0F0F_1234), 32'hF0F0_EDCB);

        // R10: write without a frame pulse has no effect yet
        goto_line(4);
        wr_reg(2'd3, 32'h0000_FF00);
        send_beat(1'b0, 14'd14, 32'h0, res);
        chk("R10 colour held until frame", res, {C1, 8'hFF});
        goto_line(4);
        send_beat(1'b0, 14'd14, 32'h0, res);
        chk("R10 colour applied at frame", res, 32'h00FF_00FF);

        // R11: lock holds, release lets next frame apply
        wr_reg(2'd1, 32'h8000_0001);
        wr_reg(2'd3, 32'h0000_00AA);
        line_check("R11 locked frame keeps colour", 12'd4, 14'd14, 32'h0);
        chk("R11 locked model", model(12'd4, 14'd14, 32'h0), 32'h00FF_00FF);
        wr_reg(2'd0, {2'b00, CX, 4'h0, CY});
        line_check("R11 released frame applies colour", 12'd4, 14'd14, 32'h0);
        chk("R11 released model", model(12'd4, 14'd14, 32'h0), 32'h0000_AAFF);

        // R9: move the cursor
        wr_reg(2'd0, {2'b00, 14'd30, 4'h0, 12'd10});
        line_check("R9 moved cursor hit", 12'd10, 14'd30, 32'h2468_ACE0);
        line_check("R9 moved cursor line above", 12'd9, 14'd30, 32'h1357_9BDF);

        // R2: output stall holds the beat
        out_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b1; in_sol = 1'b0; in_x = 14'd2; in_pix = 32'h5A5A_5A5A;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        held = out_pix;
        chk("R2 stall valid", {31'd0, out_valid}, 32'd1);
        @(negedge clk);
        chk("R2 stall hold valid", {31'd0, out_valid}, 32'd1);
        chk("R2 stall hold data", out_pix, held);
        chk("R2 stall not ready", {31'd0, in_ready}, 32'd0);
        out_ready = 1'b1;
        @(negedge clk);
        chk("R2 drained", {31'd0, out_valid}, 32'd0);

        // R7: disable
        wr_reg(2'd1, 32'h0000_0000);
        line_check("R7 disabled pass", 12'd10, 14'd30, 32'h0BAD_BEEF);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule